// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synchronous static memory whose words are made of several byte lanes, 36 bits as four 9-bit lanes by default. It accepts one read or one write command on every enabled clock. Reads are pipelined: the word addressed by a read leaves an output register one enabled edge after the command is taken. Write data lags its command by two enabled edges. It therefore occupies the same bus slot that a read's result would use, so any mix of reads and writes can be issued back to back with no idle cycle between directions.

A command is taken only when all three chip selects are in their active states. Two are active high and one is active low, so several instances can share a bus for depth expansion. A clock enable freezes the whole block for a cycle. An advance input continues the current burst instead of loading a new address. The burst steps the two low address bits in linear or interleaved order, chosen by a static order input. The output enable gates the read bus without a clock, and so does a sleep input. Sleep also blocks new commands.

Top module: `ntSram`

## Requirements
- R1: A read command taken on enabled edge k loads the addressed word into the output register at enabled edge k+1. The word is visible on rdData after that edge and stays there until the next read completes.
- R2: A write command taken on enabled edge k stores the value on wrData at enabled edge k+2. Only lanes whose laneEn bit i is 1 are written, lane i being bits 9i+8 down to 9i. laneEn is sampled with the command and has no effect on reads.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle. A read of an address whose write is still pending returns the pending data merged per lane over the stored word.
- R4: A command is taken only when selA=1, selB=1 and selN=0. In any other combination the edge issues no command, and any burst in progress ends.
- R5: With clkEn=0 the edge is ignored. No command is taken, pending writes do not advance, wrData is not sampled, and rdData holds.
- R6: A command with advance=0 loads a new burst base. With advance=1, selected, and a burst active, the next address keeps the base's upper bits and the burst's read/write type (isWrite is ignored). With orderXor=0 the low two bits are (base+n) mod 4 for the n-th advance, wrapping past 3.
- R7: With orderXor=1 the low two bits of the n-th advance are base XOR (n mod 4).
- R8: An advance while deselected, or while no burst is active (after reset or after a deselected edge), issues no command.
- R9: With outEn=0, rdData is 0 at once, without waiting for a clock edge. Restoring outEn shows the output register again at once.
- R10: With sleep=1, rdData is 0 at once and commands are ignored as if deselected. Pending writes still complete.
- R11: Reset (rstN=0) clears the output register to 0 and discards pending commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Clock enable; 0 suspends the block for that edge |
| selA | input | 1 | Chip select, active high |
| selB | input | 1 | Chip select, active high |
| selN | input | 1 | Chip select, active low |
| sleep | input | 1 | Power-down: blanks output, blocks commands |
| isWrite | input | 1 | 1 = write command, 0 = read command |
| advance | input | 1 | 1 = continue current burst |
| orderXor | input | 1 | Burst order: 0 linear, 1 interleaved |
| laneEn | input | LANES | Per-lane write enables, active high |
| addr | input | ADDR_W | Word address |
| wrData | input | LANES*LANE_W | Write data, two enabled edges after its command |
| outEn | input | 1 | Asynchronous output enable, active high |
| rdData | output | LANES*LANE_W | Registered read data, 0 when disabled |

## Verification
The bench uses the default parameters: 64 words of four 9-bit lanes. At that size the whole array can be filled with known words first, so every later read has a defined expected value. It also makes it cheap to run bursts that wrap their four-word group in both orders, and to place reads one and two edges after writes to the same word. That exercises both the forwarding path and the committed path, with full and partial lane masks. Bench-side reference queues are compared with rdData on every clock, across suspended edges, every deselect combination, sleep and output-enable changes.

// File: rtl/ntSramPkg.sv
package ntSramPkg;

  // Strobes from the control path to the datapath, already gated by clkEn.
  typedef struct packed {
    logic arrWrite;   // commit the oldest pending write this edge
    logic rdLoad;     // load the output register this edge
    logic bypassHit;  // read address matches the write committing now
  } strobe_t;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } burstOrder_t;

  localparam int BURST_W = 2;

endpackage

// File: rtl/ntSramBurst.sv
module ntSramBurst
  import ntSramPkg::*;
(
  input  logic [BURST_W-1:0] baseLow,
  input  logic [BURST_W-1:0] count,
  input  burstOrder_t        order,
  output logic [BURST_W-1:0] nextLow
);

  always_comb begin
    unique case (order)
      ORDER_XOR:    nextLow = baseLow ^ count;
      default:      nextLow = baseLow + count;
    endcase
  end

endmodule

// File: rtl/ntSramCtrl.sv
module ntSramCtrl
  import ntSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              selA,
  input  logic              selB,
  input  logic              selN,
  input  logic              sleep,
  input  logic              isWrite,
  input  logic              advance,
  input  logic              orderXor,
  input  logic [LANES-1:0]  laneEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrLanes,
  output logic [ADDR_W-1:0] rdAddr
);

  typedef struct packed {
    logic              valid;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  lanes;
  } stage_t;

  stage_t stageOne, stageTwo, stageNext;

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] burstCnt;
  logic [BURST_W-1:0] nextCnt;
  logic [BURST_W-1:0] burstLow;
  logic               burstOn;
  logic               burstWr;

  logic selected;
  logic newCmd;
  logic stepCmd;

  assign selected = selA & selB & ~selN & ~sleep;
  assign newCmd   = selected & ~advance;
  assign stepCmd  = selected & advance & burstOn;
  assign nextCnt  = burstCnt + 1'b1;

  ntSramBurst burstGen (
    .baseLow (baseAddr[BURST_W-1:0]),
    .count   (nextCnt),
    .order   (burstOrder_t'(orderXor)),
    .nextLow (burstLow)
  );

  always_comb begin
    stageNext       = '0;
    stageNext.lanes = laneEn;
    if (newCmd) begin
      stageNext.valid = 1'b1;
      stageNext.write = isWrite;
      stageNext.addr  = addr;
    end else if (stepCmd) begin
      stageNext.valid = 1'b1;
      stageNext.write = burstWr;
      stageNext.addr  = {baseAddr[ADDR_W-1:BURST_W], burstLow};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      burstCnt <= '0;
      burstOn  <= 1'b0;
      burstWr  <= 1'b0;
    end else if (clkEn) begin
      if (newCmd) begin
        baseAddr <= addr;
        burstCnt <= '0;
        burstOn  <= 1'b1;
        burstWr  <= isWrite;
      end else if (stepCmd) begin
        burstCnt <= nextCnt;
      end else if (!selected) begin
        burstOn  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageOne <= '0;
      stageTwo <= '0;
    end else if (clkEn) begin
      stageOne <= stageNext;
      stageTwo <= stageOne;
    end
  end

  always_comb begin
    strb.arrWrite  = clkEn & stageTwo.valid & stageTwo.write;
    strb.rdLoad    = clkEn & stageOne.valid & ~stageOne.write;
    strb.bypassHit = stageTwo.valid & stageTwo.write &
                     (stageTwo.addr == stageOne.addr);
  end

  assign wrAddr  = stageTwo.addr;
  assign wrLanes = stageTwo.lanes;
  assign rdAddr  = stageOne.addr;

  // R5: a suspended edge leaves both pipeline stages untouched
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(stageOne) && $stable(stageTwo)));

  // R4: an unselected enabled edge puts no command into the pipeline
  assert_desel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !selected) |=> !stageOne.valid);

  // R6: an advance keeps the upper address bits of the burst base
  assert_upper_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && stepCmd) |=>
      (stageOne.addr[ADDR_W-1:BURST_W] == $past(baseAddr[ADDR_W-1:BURST_W])));

  // R2: a write moves to the commit stage with its address and lanes intact
  assert_pipe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && stageOne.valid && stageOne.write) |=>
      (stageTwo.valid && stageTwo.write &&
       stageTwo.addr == $past(stageOne.addr) &&
       stageTwo.lanes == $past(stageOne.lanes)));

endmodule

// File: rtl/ntSramData.sv
module ntSramData
  import ntSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEn,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrLanes,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES*LANE_W-1:0] wrData,
  output logic [LANES*LANE_W-1:0] outReg
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (strb.arrWrite) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrLanes[i]) memArr[wrAddr][i*LANE_W +: LANE_W] <= wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    rdWord = memArr[rdAddr];
    if (strb.bypassHit) begin
      for (int i = 0; i < LANES; i++) begin
        if (wrLanes[i]) rdWord[i*LANE_W +: LANE_W] = wrData[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strb.rdLoad) outReg <= rdWord;
  end

  // R5: the output register does not move on a suspended edge
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(outReg));

  // R3: a read colliding with a full-word commit returns the bus data
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && strb.bypassHit && (&wrLanes)) |=> (outReg == $past(wrData)));

endmodule

// File: rtl/ntSram.sv
module ntSram
  import ntSramPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEn,
  input  logic                    selA,
  input  logic                    selB,
  input  logic                    selN,
  input  logic                    sleep,
  input  logic                    isWrite,
  input  logic                    advance,
  input  logic                    orderXor,
  input  logic [LANES-1:0]        laneEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] rdData
);

  strobe_t                 strb;
  logic [ADDR_W-1:0]       wrAddr;
  logic [ADDR_W-1:0]       rdAddr;
  logic [LANES-1:0]        wrLanes;
  logic [LANES*LANE_W-1:0] outReg;

  ntSramCtrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .selA     (selA),
    .selB     (selB),
    .selN     (selN),
    .sleep    (sleep),
    .isWrite  (isWrite),
    .advance  (advance),
    .orderXor (orderXor),
    .laneEn   (laneEn),
    .addr     (addr),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .wrLanes  (wrLanes),
    .rdAddr   (rdAddr)
  );

  ntSramData #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .clkEn   (clkEn),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .wrLanes (wrLanes),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .outReg  (outReg)
  );

  assign rdData = (outEn && !sleep) ? outReg : '0;

endmodule

// File: tb/ntSram_tb_top.sv
`timescale 1ns/1ps
module ntSram_tb_top;

  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int WW = LN * LW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEn = 1'b1;
  logic          selA = 1'b0, selB = 1'b1, selN = 1'b0;
  logic          sleep = 1'b0;
  logic          isWrite = 1'b0;
  logic          advance = 1'b0;
  logic          orderXor = 1'b0;
  logic [LN-1:0] laneEn = '1;
  logic [AW-1:0] addr = '0;
  logic [WW-1:0] wrData = '0;
  logic          outEn = 1'b1;
  logic [WW-1:0] rdData;

  int  tests = 0;
  int  fails = 0;
  bit  done = 0;

  ntSram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .selA(selA), .selB(selB),
    .selN(selN), .sleep(sleep), .isWrite(isWrite), .advance(advance),
    .orderXor(orderXor), .laneEn(laneEn), .addr(addr), .wrData(wrData),
    .outEn(outEn), .rdData(rdData)
  );

  always #2 clk = ~clk;

  // ---------------- reference model ----------------
  typedef struct {
    bit            v;
    bit            w;
    logic [AW-1:0] a;
    logic [LN-1:0] ln;
  } ent_t;

  ent_t          pipe[$];
  logic [WW-1:0] mem [1<<AW];
  logic [WW-1:0] expOut = '0;
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mCnt = '0;
  bit            mOn = 0;
  bit            mWr = 0;

  always @(posedge clk) begin
    ent_t e, n;
    bit sel;
    logic [1:0] low;
    if (!rstN) begin
      pipe.delete();
      expOut = '0;
      mOn = 0;
    end else if (clkEn) begin
      if (pipe.size() == 2) begin
        e = pipe.pop_front();
        if (e.v && e.w)
          for (int i = 0; i < LN; i++)
            if (e.ln[i]) mem[e.a][i*LW +: LW] = wrData[i*LW +: LW];
      end
      if (pipe.size() == 1 && pipe[0].v && !pipe[0].w) expOut = mem[pipe[0].a];
      sel = selA && selB && !selN && !sleep;
      n = '{v: 0, w: 0, a: '0, ln: laneEn};
      if (sel && !advance) begin
        mBase = addr; mCnt = 0; mOn = 1; mWr = isWrite;
        n.v = 1; n.w = isWrite; n.a = addr;
      end else if (sel && advance && mOn) begin
        mCnt = mCnt + 2'd1;
        low = orderXor ? (mBase[1:0] ^ mCnt) : (mBase[1:0] + mCnt);
        n.v = 1; n.w = mWr; n.a = {mBase[AW-1:2], low};
      end else if (!sel) begin
        mOn = 0;
      end
      pipe.push_back(n);
    end
  end

  // ---------------- driver ----------------
  logic [WW-1:0] dq[$];

  task automatic check(input string tag);
    logic [WW-1:0] exp;
    exp = (outEn && !sleep) ? expOut : '0;
    tests++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s: rdData=%h expected %h", tag, rdData, exp);
    end
  endtask

  task automatic step(input bit en, input bit sA, input bit sB, input bit sN,
                      input bit w, input bit adv, input logic [AW-1:0] a,
                      input logic [LN-1:0] ln, input logic [WW-1:0] d,
                      input string tag);
    clkEn = en; selA = sA; selB = sB; selN = sN;
    isWrite = w; advance = adv; addr = a; laneEn = ln;
    if (en) begin
      if (dq.size() == 2) wrData = dq.pop_front();
      else wrData = {$urandom, 4'h5};
      dq.push_back(d);
    end else begin
      wrData = {$urandom, 4'hA};
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] ln,
                    input logic [WW-1:0] d, input string tag);
    step(1, 1, 1, 0, 1, 0, a, ln, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1, 1, 1, 0, 0, 0, a, '1, {$urandom, 4'h3}, tag);
  endtask

  task automatic nop(input string tag);
    step(1, 0, 1, 0, 0, 0, '0, '1, {$urandom, 4'h1}, tag);
  endtask

  task automatic adv(input logic [WW-1:0] d, input string tag);
    step(1, 1, 1, 0, 0, 1, 6'h3F, '1, d, tag);
  endtask

  task automatic nowCheck(input string tag);
    #1;
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    nop("R11 reset");
    nop("R11 reset");
    rstN = 1'b1;
    dq.delete();
    nop("R11 after reset");

    for (int i = 0; i < (1 << AW); i++)
      wr(AW'(i), '1, WW'(i) * 36'h0_0F1E_2D3 + 36'h1, "R2 fill");
    nop("R2 fill drain"); nop("R2 fill drain"); nop("R2 fill drain");

    for (int i = 0; i < 8; i++) rd(AW'(i * 5), "R1 pipelined read");
    nop("R1 drain"); nop("R1 drain");

    wr(10, 4'b0101, 36'hF_FFFF_FFFF, "R2 lane mask");
    nop("R2"); nop("R2");
    rd(10, "R2 lane mask read"); nop("R2"); nop("R2");

    wr(20, 4'hF, 36'hA_BCDE_F012, "R3 mix");
    rd(20, "R3 forward full");
    wr(21, 4'b0011, 36'h1_2345_6789, "R3 mix");
    rd(21, "R3 forward partial");
    rd(20, "R3 committed read");
    wr(20, 4'b1000, 36'h5_5555_5555, "R3 mix");
    rd(20, "R3 forward top lane");
    rd(21, "R3 back to back");
    wr(22, 4'hF, 36'h0_0000_0F0F, "R3 mix");
    rd(22, "R3 forward again");
    nop("R3 drain"); nop("R3 drain"); nop("R3 drain");

    step(1, 0, 1, 0, 1, 0, 30, '1, 36'h0, "R4 selA low");
    step(1, 1, 0, 0, 1, 0, 30, '1, 36'h0, "R4 selB low");
    step(1, 1, 1, 1, 1, 0, 30, '1, 36'h0, "R4 selN high");
    nop("R4"); nop("R4");
    rd(30, "R4 word unchanged");
    step(1, 1, 1, 1, 0, 0, 31, '1, 36'h0, "R4 deselected read");
    nop("R4 output holds"); nop("R4 output holds");

    wr(40, 4'hF, 36'h3_3333_3333, "R5 write");
    step(0, 1, 1, 0, 1, 0, 40, '1, 36'h0, "R5 suspended");
    step(0, 1, 1, 0, 0, 0, 41, '1, 36'h0, "R5 suspended");
    nop("R5"); nop("R5");
    rd(40, "R5 data after suspend");
    rd(41, "R5 read");
    step(0, 1, 1, 0, 0, 0, 42, '1, 36'h0, "R5 output holds");
    step(0, 1, 1, 0, 0, 0, 43, '1, 36'h0, "R5 output holds");
    nop("R5 resume"); nop("R5 resume");

    orderXor = 1'b0;
    rd(6, "R6 linear base");
    adv('0, "R6 linear"); adv('0, "R6 linear"); adv('0, "R6 linear wrap");
    adv('0, "R6 linear wrap"); nop("R6"); nop("R6");
    wr(13, 4'hF, 36'h1_1111_1111, "R6 write burst");
    adv(36'h2_2222_2222, "R6 write burst");
    adv(36'h4_4444_4444, "R6 write burst");
    step(1, 1, 1, 0, 0, 1, 6'h3F, 4'b0001, 36'h7_7777_7777, "R6 write burst lane");
    nop("R6"); nop("R6");
    for (int i = 12; i < 16; i++) rd(AW'(i), "R6 write burst readback");
    nop("R6"); nop("R6");

    orderXor = 1'b1;
    rd(25, "R7 xor base");
    adv('0, "R7 xor"); adv('0, "R7 xor"); adv('0, "R7 xor"); adv('0, "R7 xor wrap");
    nop("R7"); nop("R7");
    wr(18, 4'hF, 36'h8_0000_0001, "R7 write burst");
    adv(36'h8_0000_0002, "R7 write burst");
    adv(36'h8_0000_0003, "R7 write burst");
    adv(36'h8_0000_0004, "R7 write burst");
    nop("R7"); nop("R7");
    for (int i = 16; i < 20; i++) rd(AW'(i), "R7 write burst readback");
    nop("R7"); nop("R7");
    orderXor = 1'b0;

    adv('0, "R8 advance without burst"); adv('0, "R8 advance without burst");
    nop("R8"); nop("R8");
    rd(5, "R8 start");
    step(1, 0, 1, 0, 0, 1, 0, '1, '0, "R8 advance deselected");
    adv('0, "R8 burst ended"); adv('0, "R8 burst ended");
    nop("R8"); nop("R8");

    rd(7, "R9 prep"); nop("R9"); nop("R9");
    outEn = 1'b0; nowCheck("R9 async disable");
    rd(8, "R9 disabled"); nop("R9 disabled"); nop("R9 disabled");
    outEn = 1'b1; nowCheck("R9 async enable");
    nop("R9");

    sleep = 1'b1; nowCheck("R10 sleep blanks");
    wr(7, 4'hF, 36'hD_EAD0_BEEF, "R10 write in sleep");
    rd(9, "R10 read in sleep");
    nop("R10"); nop("R10");
    sleep = 1'b0; nowCheck("R10 wake");
    rd(7, "R10 word unchanged"); nop("R10"); nop("R10");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule